// File: doc/BRIEF.md
# Memory-Mapped Register Software Lock

This block sits in front of a bank of memory-mapped monitor registers and protects them from stray writes. Software releases the lock by writing a fixed 32-bit key to a write-only lock-access register, and engages it again by writing any other value there. A read-only lock-status register reports whether the lock is built in and whether it is engaged. For every access to the guarded bank, the block produces two qualifiers: a write enable, and an enable for read side effects. The guarded bank uses these qualifiers, and that bank is not part of this block.

The register port handles one access per cycle and answers it in the same cycle. Read data and the error flag are combinational, and there is no back-pressure. The only state in the block is the lock itself. A parameter chooses the reset domain of the lock: the core domain (reset by cold reset) or the debug domain (reset by external debug reset). The block has no warm reset input, so a warm reset elsewhere in the chip cannot change the lock. In the core-domain option, an access made while the core is unpowered returns an error.

Top module: `swlock_ctrl`

## Requirements
- R1: After the reset of the selected domain, the lock is engaged. A memory-mapped read of the status register at offset `STAT_OFS` then returns 32'h3: bit 0 is lock-implemented and bit 1 is lock-engaged.
- R2: A memory-mapped write of `KEY` (default 32'h5A1EC0DE) to the lock-access register at `KEY_OFS` releases the lock from the next cycle on.
- R3: A memory-mapped write of any value other than `KEY` to the lock-access register engages the lock from the next cycle on.
- R4: While the lock is engaged, a memory-mapped access to the guarded bank drives `bank_wr_en` low on a write and `bank_rd_fx_en` low on a read. The guarded bank is every offset other than `KEY_OFS` and `STAT_OFS`.
- R5: While the lock is released, a valid access to the guarded bank raises `bank_wr_en` on a write and `bank_rd_fx_en` on a read, in the same cycle as the access.
- R6: For an access that is not memory-mapped (`req_mmap`=0), three things hold. The status register reads as zero. Writes to the lock-access register leave the lock unchanged. The lock does not block guarded-bank qualifiers.
- R7: With `CORE_DOMAIN`=1, `cold_rst_n` engages the lock and `dbg_rst_n` leaves it unchanged. With `CORE_DOMAIN`=0, the roles of the two resets are swapped.
- R8: With `CORE_DOMAIN`=1 and `core_pwr`=0, any valid access has the following results. `rsp_err` is 1. Read data is 0. Both qualifiers are 0. The lock does not change. With `CORE_DOMAIN`=0, `rsp_err` is always 0.
- R9: The lock-access register reads as zero. A write to the status register changes nothing and raises no error. Status bit 2 (the "32-bit access required" flag) always reads as zero.
- R10: With `LOCK_IMPL`=0, every read returns zero and the guarded-bank qualifiers are never blocked.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| cold_rst_n | input | 1 | Cold reset, active low, asynchronous |
| dbg_rst_n | input | 1 | External debug reset, active low, asynchronous |
| core_pwr | input | 1 | Core power domain is up |
| req_valid | input | 1 | An access is present this cycle |
| req_mmap | input | 1 | 1 = memory-mapped path, 0 = external debug path |
| req_we | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Register offset |
| req_wdata | input | DATA_W | Write data |
| rsp_rdata | output | DATA_W | Read data, combinational |
| rsp_err | output | 1 | Error response, combinational |
| bank_wr_en | output | 1 | Write permitted to guarded bank |
| bank_rd_fx_en | output | 1 | Read side effects permitted in guarded bank |

## Verification
The assertions assume that every request field is a known value whenever `req_valid` is high. They also assume that at least one reset is applied before the first access is checked, because they are disabled while either reset is low. The bench drives all request fields on the falling edge and keeps them at defined values throughout. It applies both resets from time zero, and it pulses each reset only between accesses. Three configurations (core domain, debug domain, lock not built in) share one request stream. This lets the power-off and reset-domain cases be compared side by side.

// File: rtl/swlock_pkg.sv
package swlock_pkg;
  // Status register field positions
  localparam int ST_IMPL_POS = 0;
  localparam int ST_LOCK_POS = 1;
  localparam int ST_WIDE_POS = 2;

  typedef struct packed {
    logic ok;        // valid and serviceable
    logic err;       // valid but refused (core unpowered)
    logic hit_key;   // lock-access register
    logic hit_stat;  // lock-status register
    logic hit_bank;  // guarded bank
  } acc_t;
endpackage

// File: rtl/swlock_decode.sv
module swlock_decode
  import swlock_pkg::*;
#(
  parameter bit              CORE_DOMAIN = 1'b1,
  parameter int              ADDR_W      = 12,
  parameter logic [ADDR_W-1:0] KEY_OFS   = 12'hFA0,
  parameter logic [ADDR_W-1:0] STAT_OFS  = 12'hFA4
) (
  input  logic              req_valid,
  input  logic              req_we,
  input  logic              req_mmap,
  input  logic              core_pwr,
  input  logic              lock_eff,
  input  logic [ADDR_W-1:0] req_addr,
  output acc_t              acc,
  output logic              bank_wr_en,
  output logic              bank_rd_fx_en
);
  logic unpowered;
  logic pass;

  generate
    if (CORE_DOMAIN) begin : g_core
      assign unpowered = ~core_pwr;
    end else begin : g_dbg
      assign unpowered = 1'b0;
    end
  endgenerate

  always_comb begin
    acc.hit_key  = (req_addr == KEY_OFS);
    acc.hit_stat = (req_addr == STAT_OFS);
    acc.hit_bank = ~acc.hit_key & ~acc.hit_stat;
    acc.err      = req_valid & unpowered;
    acc.ok       = req_valid & ~unpowered;
    // only memory-mapped traffic is subject to the lock
    pass          = ~(req_mmap & lock_eff);
    bank_wr_en    = acc.ok & acc.hit_bank & req_we & pass;
    bank_rd_fx_en = acc.ok & acc.hit_bank & ~req_we & pass;
  end
endmodule

// File: rtl/swlock_state.sv
module swlock_state #(
  parameter bit              CORE_DOMAIN = 1'b1,
  parameter bit              LOCK_IMPL   = 1'b1,
  parameter int              DATA_W      = 32,
  parameter logic [DATA_W-1:0] KEY       = 32'h5A1E_C0DE
) (
  input  logic              clk,
  input  logic              cold_rst_n,
  input  logic              dbg_rst_n,
  input  logic              upd,
  input  logic [DATA_W-1:0] wdata,
  output logic              lock_q
);
  generate
    if (LOCK_IMPL) begin : g_lock
      logic dom_rst_n;
      if (CORE_DOMAIN) begin : g_cold
        assign dom_rst_n = cold_rst_n;
      end else begin : g_debug
        assign dom_rst_n = dbg_rst_n;
      end
      always_ff @(posedge clk or negedge dom_rst_n) begin
        if (!dom_rst_n)  lock_q <= 1'b1;
        else if (upd)    lock_q <= (wdata != KEY);
      end
    end else begin : g_none
      assign lock_q = 1'b0;
    end
  endgenerate
endmodule

// File: rtl/swlock_status.sv
module swlock_status
  import swlock_pkg::*;
#(
  parameter int DATA_W    = 32,
  parameter bit LOCK_IMPL = 1'b1
) (
  input  logic              rd_stat,
  input  logic              lock_q,
  output logic [DATA_W-1:0] rdata
);
  always_comb begin
    rdata = '0;
    if (LOCK_IMPL && rd_stat) begin
      rdata[ST_IMPL_POS] = 1'b1;
      rdata[ST_LOCK_POS] = lock_q;
      rdata[ST_WIDE_POS] = 1'b0;
    end
  end
endmodule

// File: rtl/swlock_ctrl.sv
module swlock_ctrl
  import swlock_pkg::*;
#(
  parameter bit                CORE_DOMAIN = 1'b1,
  parameter bit                LOCK_IMPL   = 1'b1,
  parameter int                ADDR_W      = 12,
  parameter int                DATA_W      = 32,
  parameter logic [DATA_W-1:0] KEY         = 32'h5A1E_C0DE,
  parameter logic [ADDR_W-1:0] KEY_OFS     = 12'hFA0,
  parameter logic [ADDR_W-1:0] STAT_OFS    = 12'hFA4
) (
  input  logic              clk,
  input  logic              cold_rst_n,
  input  logic              dbg_rst_n,
  input  logic              core_pwr,
  input  logic              req_valid,
  input  logic              req_mmap,
  input  logic              req_we,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              rsp_err,
  output logic              bank_wr_en,
  output logic              bank_rd_fx_en
);
  acc_t acc;
  logic lock_q;
  logic key_upd;
  logic rd_stat;

  swlock_decode #(
    .CORE_DOMAIN(CORE_DOMAIN), .ADDR_W(ADDR_W),
    .KEY_OFS(KEY_OFS), .STAT_OFS(STAT_OFS)
  ) u_dec (
    .req_valid    (req_valid),
    .req_we       (req_we),
    .req_mmap     (req_mmap),
    .core_pwr     (core_pwr),
    .lock_eff     (lock_q),
    .req_addr     (req_addr),
    .acc          (acc),
    .bank_wr_en   (bank_wr_en),
    .bank_rd_fx_en(bank_rd_fx_en)
  );

  assign key_upd = acc.ok & req_we & req_mmap & acc.hit_key;
  assign rd_stat = acc.ok & ~req_we & req_mmap & acc.hit_stat;

  swlock_state #(
    .CORE_DOMAIN(CORE_DOMAIN), .LOCK_IMPL(LOCK_IMPL),
    .DATA_W(DATA_W), .KEY(KEY)
  ) u_state (
    .clk       (clk),
    .cold_rst_n(cold_rst_n),
    .dbg_rst_n (dbg_rst_n),
    .upd       (key_upd),
    .wdata     (req_wdata),
    .lock_q    (lock_q)
  );

  swlock_status #(.DATA_W(DATA_W), .LOCK_IMPL(LOCK_IMPL)) u_stat (
    .rd_stat(rd_stat),
    .lock_q (lock_q),
    .rdata  (rsp_rdata)
  );

  assign rsp_err = acc.err;
endmodule

// File: rtl/swlock_chk.sv
module swlock_chk #(
  parameter bit                CORE_DOMAIN = 1'b1,
  parameter bit                LOCK_IMPL   = 1'b1,
  parameter int                ADDR_W      = 12,
  parameter int                DATA_W      = 32,
  parameter logic [DATA_W-1:0] KEY         = 32'h5A1E_C0DE,
  parameter logic [ADDR_W-1:0] KEY_OFS     = 12'hFA0
) (
  input logic              clk,
  input logic              cold_rst_n,
  input logic              dbg_rst_n,
  input logic              core_pwr,
  input logic              req_valid,
  input logic              req_mmap,
  input logic              req_we,
  input logic [ADDR_W-1:0] req_addr,
  input logic [DATA_W-1:0] req_wdata,
  input logic [DATA_W-1:0] rsp_rdata,
  input logic              rsp_err,
  input logic              bank_wr_en,
  input logic              bank_rd_fx_en,
  input logic              lock_q
);
  logic key_wr;
  assign key_wr = LOCK_IMPL && req_valid && req_we && req_mmap &&
                  (req_addr == KEY_OFS) && !rsp_err;

  // R4
  locked_blocks_chk: assert property (@(posedge clk) disable iff (!cold_rst_n || !dbg_rst_n)
    (lock_q && req_mmap) |-> (!bank_wr_en && !bank_rd_fx_en));

  // R2
  key_release_chk: assert property (@(posedge clk) disable iff (!cold_rst_n || !dbg_rst_n)
    (key_wr && req_wdata == KEY) |=> !lock_q);

  // R3
  other_engage_chk: assert property (@(posedge clk) disable iff (!cold_rst_n || !dbg_rst_n)
    (key_wr && req_wdata != KEY) |=> lock_q);

  // R8
  unpowered_err_chk: assert property (@(posedge clk) disable iff (!cold_rst_n || !dbg_rst_n)
    (CORE_DOMAIN && req_valid && !core_pwr) |-> (rsp_err && rsp_rdata == '0 && !bank_wr_en && !bank_rd_fx_en));

  // R8
  unpowered_hold_chk: assert property (@(posedge clk) disable iff (!cold_rst_n || !dbg_rst_n)
    (rsp_err) |=> $stable(lock_q));

  // R6
  debug_zero_chk: assert property (@(posedge clk) disable iff (!cold_rst_n || !dbg_rst_n)
    (req_valid && !req_mmap) |-> (rsp_rdata == '0));

  // R9
  wide_flag_chk: assert property (@(posedge clk) disable iff (!cold_rst_n || !dbg_rst_n)
    rsp_rdata[2] == 1'b0);

  // R9
  no_spurious_err_chk: assert property (@(posedge clk) disable iff (!cold_rst_n || !dbg_rst_n)
    (!req_valid || core_pwr) |-> !rsp_err);
endmodule

bind swlock_ctrl swlock_chk #(
  .CORE_DOMAIN(CORE_DOMAIN), .LOCK_IMPL(LOCK_IMPL), .ADDR_W(ADDR_W),
  .DATA_W(DATA_W), .KEY(KEY), .KEY_OFS(KEY_OFS)
) u_chk (
  .clk(clk), .cold_rst_n(cold_rst_n), .dbg_rst_n(dbg_rst_n), .core_pwr(core_pwr),
  .req_valid(req_valid), .req_mmap(req_mmap), .req_we(req_we), .req_addr(req_addr),
  .req_wdata(req_wdata), .rsp_rdata(rsp_rdata), .rsp_err(rsp_err),
  .bank_wr_en(bank_wr_en), .bank_rd_fx_en(bank_rd_fx_en), .lock_q(lock_q)
);

// File: tb/sim_swlock_ctrl.sv
module sim_swlock_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam logic [31:0] KEY   = 32'h5A1E_C0DE;
  localparam logic [11:0] A_KEY = 12'hFA0;
  localparam logic [11:0] A_ST  = 12'hFA4;

  logic clk = 1'b0;
  logic cold_rst_n = 1'b0, dbg_rst_n = 1'b0;
  logic core_pwr = 1'b1, req_valid = 1'b0, req_mmap = 1'b0, req_we = 1'b0;
  logic [11:0] req_addr = '0;
  logic [31:0] req_wdata = '0;

  logic [31:0] rd0, rd1, rd2;
  logic er0, er1, er2, w0, w1, w2, f0, f1, f2;

  int n_chk = 0, n_fail = 0;
  bit m_lock [3];
  bit p_core [3] = '{1'b1, 1'b0, 1'b1};
  bit p_impl [3] = '{1'b1, 1'b1, 1'b0};

  always #(CLK_PERIOD/2) clk = ~clk;

  swlock_ctrl #(.CORE_DOMAIN(1'b1), .LOCK_IMPL(1'b1)) u0 (
    .clk(clk), .cold_rst_n(cold_rst_n), .dbg_rst_n(dbg_rst_n), .core_pwr(core_pwr),
    .req_valid(req_valid), .req_mmap(req_mmap), .req_we(req_we), .req_addr(req_addr),
    .req_wdata(req_wdata), .rsp_rdata(rd0), .rsp_err(er0), .bank_wr_en(w0), .bank_rd_fx_en(f0));
  swlock_ctrl #(.CORE_DOMAIN(1'b0), .LOCK_IMPL(1'b1)) u1 (
    .clk(clk), .cold_rst_n(cold_rst_n), .dbg_rst_n(dbg_rst_n), .core_pwr(core_pwr),
    .req_valid(req_valid), .req_mmap(req_mmap), .req_we(req_we), .req_addr(req_addr),
    .req_wdata(req_wdata), .rsp_rdata(rd1), .rsp_err(er1), .bank_wr_en(w1), .bank_rd_fx_en(f1));
  swlock_ctrl #(.CORE_DOMAIN(1'b1), .LOCK_IMPL(1'b0)) u2 (
    .clk(clk), .cold_rst_n(cold_rst_n), .dbg_rst_n(dbg_rst_n), .core_pwr(core_pwr),
    .req_valid(req_valid), .req_mmap(req_mmap), .req_we(req_we), .req_addr(req_addr),
    .req_wdata(req_wdata), .rsp_rdata(rd2), .rsp_err(er2), .bank_wr_en(w2), .bank_rd_fx_en(f2));

  task automatic chk(string tag, string what, int i, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s u%0d %s: actual %h expected %h", tag, i, what, act, exp);
    end
  endtask

  // reference: outputs of configuration i for the current request
  task automatic compare(string tag);
    for (int i = 0; i < 3; i++) begin
      bit err, ok, guard, lk, pass;
      logic [31:0] e_rd;
      logic [31:0] a_rd;
      logic a_er, a_w, a_f;
      err   = req_valid && p_core[i] && !core_pwr;
      ok    = req_valid && !err;
      guard = (req_addr != A_KEY) && (req_addr != A_ST);
      lk    = p_impl[i] && m_lock[i];
      pass  = !(req_mmap && lk);
      e_rd  = (ok && !req_we && req_mmap && p_impl[i] && req_addr == A_ST) ?
              (32'd1 | (32'(m_lock[i]) << 1)) : 32'd0;
      case (i)
        0: begin a_rd = rd0; a_er = er0; a_w = w0; a_f = f0; end
        1: begin a_rd = rd1; a_er = er1; a_w = w1; a_f = f1; end
        default: begin a_rd = rd2; a_er = er2; a_w = w2; a_f = f2; end
      endcase
      chk(tag, "rdata", i, a_rd, e_rd);
      chk(tag, "err", i, 32'(a_er), 32'(err));
      chk(tag, "wr_en", i, 32'(a_w), 32'(ok && req_we && guard && pass));
      chk(tag, "rd_fx_en", i, 32'(a_f), 32'(ok && !req_we && guard && pass));
    end
  endtask

  task automatic acc(string tag, bit v, bit mm, bit we, logic [11:0] a, logic [31:0] d, bit pwr);
    @(negedge clk);
    req_valid = v; req_mmap = mm; req_we = we; req_addr = a; req_wdata = d; core_pwr = pwr;
    #1 compare(tag);
    @(posedge clk);
    for (int i = 0; i < 3; i++)
      if (p_impl[i] && v && !(p_core[i] && !pwr) && we && mm && a == A_KEY)
        m_lock[i] = (d != KEY);
  endtask

  task automatic pulse_reset(bit cold);
    @(negedge clk);
    req_valid = 1'b0;
    if (cold) cold_rst_n = 1'b0; else dbg_rst_n = 1'b0;
    for (int i = 0; i < 3; i++) if (p_core[i] == cold) m_lock[i] = 1'b1;
    @(negedge clk);
    cold_rst_n = 1'b1; dbg_rst_n = 1'b1;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    for (int i = 0; i < 3; i++) m_lock[i] = 1'b1;
    repeat (3) @(negedge clk);
    cold_rst_n = 1'b1; dbg_rst_n = 1'b1;
    // R1 / R10: engaged after reset; unimplemented reads zero
    acc("R1", 1, 1, 0, A_ST, 0, 1);
    acc("R10", 1, 1, 0, A_ST, 0, 1);
    // R4: guarded writes and reads blocked while engaged
    acc("R4", 1, 1, 1, 12'h010, 32'h1234, 1);
    acc("R4", 1, 1, 0, 12'h010, 0, 1);
    // R6: debug path
    acc("R6", 1, 0, 1, 12'h010, 32'h55, 1);
    acc("R6", 1, 0, 0, A_ST, 0, 1);
    acc("R6", 1, 0, 1, A_KEY, KEY, 1);
    acc("R6", 1, 1, 0, A_ST, 0, 1);
    // R2: key releases
    acc("R2", 1, 1, 1, A_KEY, KEY, 1);
    acc("R2", 1, 1, 0, A_ST, 0, 1);
    // R5: guarded access allowed
    acc("R5", 1, 1, 1, 12'h3FC, 32'hA5, 1);
    acc("R5", 1, 1, 0, 12'h000, 0, 1);
    // R9: key register reads zero, status write ignored
    acc("R9", 1, 1, 0, A_KEY, 0, 1);
    acc("R9", 1, 1, 1, A_ST, 32'hFFFF_FFFF, 1);
    acc("R9", 1, 1, 0, A_ST, 0, 1);
    // R3: other value engages
    acc("R3", 1, 1, 1, A_KEY, KEY ^ 32'h1, 1);
    acc("R3", 1, 1, 0, A_ST, 0, 1);
    acc("R2", 1, 1, 1, A_KEY, KEY, 1);
    // R8: unpowered core
    acc("R8", 1, 1, 0, A_ST, 0, 0);
    acc("R8", 1, 1, 1, A_KEY, 32'h0, 0);
    acc("R8", 1, 1, 1, 12'h020, 32'h9, 0);
    acc("R8", 1, 1, 0, A_ST, 0, 1);
    // R7: reset domains
    pulse_reset(1'b1);
    acc("R7", 1, 1, 0, A_ST, 0, 1);
    acc("R2", 1, 1, 1, A_KEY, KEY, 1);
    pulse_reset(1'b0);
    acc("R7", 1, 1, 0, A_ST, 0, 1);
    acc("R7", 1, 1, 1, 12'h040, 32'h7, 1);
    // mixed traffic
    for (int n = 0; n < 400; n++) begin
      logic [11:0] a;
      logic [31:0] d;
      case ($urandom % 5)
        0: a = A_KEY;
        1: a = A_ST;
        2: a = 12'h010;
        3: a = 12'h7FC;
        default: a = 12'h000;
      endcase
      d = ($urandom % 3 == 0) ? KEY : $urandom;
      acc("R4", ($urandom % 6) != 0, $urandom % 4 != 0, $urandom % 2 == 1, a, d, ($urandom % 8) != 0);
    end
    @(negedge clk);
    req_valid = 1'b0;
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule